// File: doc/BRIEF.md
# Integer Execute ALU with Immediate Operands

This block is the combinational execute stage of a 32-bit load-store processor core. Each cycle it receives an operation code and up to three operands: two register values, a 16-bit constant taken from the instruction, and a 5-bit shift count. It returns one 32-bit result in the same cycle. The decode stage upstream supplies the operation code. The register file downstream captures the result.

Every operation reads its first operand from `src_a`. Register forms take the second operand from `src_b`. Immediate forms take it from `imm16`, which is widened according to the operation: arithmetic forms sign-extend it, and bitwise forms zero-extend it. The load-upper form moves the constant into the top half of the word. A 32-bit constant is built from a load-upper followed by an OR-immediate. A bitwise NOT is obtained as a NOR with a zero second operand.

Top module: `int_exec_alu`

## Requirements
- R1: Op code 0 (add) returns `src_a + src_b`, and op code 1 (subtract) returns `src_a - src_b`.
- R2: Addition and subtraction wrap modulo 2^32. Neither raises a flag or changes any output other than `result`.
- R3: Subtraction uses `src_a` as the minuend, so swapping the operands gives the two's complement negation of the result.
- R4: Op code 8 (add-immediate) sign-extends `imm16` from bit 15 and adds it to `src_a`. An `imm16` of 0x8000 therefore adds -32768.
- R5: Op codes 9, 10 and 11 (AND/OR/XOR-immediate) zero-extend `imm16` and combine it bitwise with `src_a`. OR-immediate with 0x0FFF sets the low 12 bits, and AND-immediate with 0x0FFF keeps only the low 12 bits.
- R6: Op code 2 (shift left) and op code 3 (shift right) move `src_a` by `shamt` (0 to 31) and fill the vacated bits with zeros. A shift by 0 returns `src_a` unchanged.
- R7: Op codes 4, 5 and 7 return the bitwise AND, OR and XOR of `src_a` and `src_b`.
- R8: Op code 6 returns the bitwise NOR of `src_a` and `src_b`. With `src_b` zero it is the bitwise NOT of `src_a`.
- R9: Op code 12 (load-upper) returns `imm16` in bits 31:16 and zero in bits 15:0, and it ignores `src_a`.
- R10: Op codes 13, 14 and 15 return zero.
- R11: Register forms ignore `imm16`. Immediate forms and shifts ignore `src_b`.
- R12: `result` is purely combinational and reflects the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 shift left, 3 shift right, 4 and, 5 or, 6 nor, 7 xor, 8 add-imm, 9 and-imm, 10 or-imm, 11 xor-imm, 12 load-upper) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Instruction constant |
| shamt | input | 5 | Shift count |
| result | output | 32 | Operation result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and `result`. The bench changes the inputs on a rising clock edge and samples `result` at the following falling edge. That leaves half a period for the combinational path to settle and keeps each sample clear of the edge where inputs move. Chained cases, such as a load-upper whose result is fed into an OR-immediate, follow the same rule. The bench copies the first result into `src_a` before it applies the second operation, so no case depends on timing between the two.

// File: rtl/int_exec_alu_pkg.sv
package int_exec_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLL  = 4'd2,
        OP_SRL  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_NOR  = 4'd6,
        OP_XOR  = 4'd7,
        OP_ADDI = 4'd8,
        OP_ANDI = 4'd9,
        OP_ORI  = 4'd10,
        OP_XORI = 4'd11,
        OP_LUI  = 4'd12
    } op_e;

    typedef enum logic [2:0] {
        U_ZERO,
        U_ARITH,
        U_SHIFT,
        U_LOGIC,
        U_PASS
    } unit_e;

    typedef enum logic [1:0] {
        L_AND,
        L_OR,
        L_NOR,
        L_XOR
    } logic_e;

    typedef enum logic [1:0] {
        B_REG,
        B_SEXT,
        B_ZEXT,
        B_UPPER
    } bsel_e;

    typedef struct packed {
        unit_e  unit;
        logic   sub;
        logic   shl;
        logic_e lop;
        bsel_e  bsel;
    } ctrl_t;

    function automatic ctrl_t decode_op(input logic [3:0] code);
        ctrl_t c;
        c.unit = U_ZERO;
        c.sub  = 1'b0;
        c.shl  = 1'b0;
        c.lop  = L_AND;
        c.bsel = B_REG;
        case (op_e'(code))
            OP_ADD:  c.unit = U_ARITH;
            OP_SUB:  begin c.unit = U_ARITH; c.sub = 1'b1; end
            OP_SLL:  begin c.unit = U_SHIFT; c.shl = 1'b1; end
            OP_SRL:  c.unit = U_SHIFT;
            OP_AND:  begin c.unit = U_LOGIC; c.lop = L_AND; end
            OP_OR:   begin c.unit = U_LOGIC; c.lop = L_OR;  end
            OP_NOR:  begin c.unit = U_LOGIC; c.lop = L_NOR; end
            OP_XOR:  begin c.unit = U_LOGIC; c.lop = L_XOR; end
            OP_ADDI: begin c.unit = U_ARITH; c.bsel = B_SEXT; end
            OP_ANDI: begin c.unit = U_LOGIC; c.lop = L_AND; c.bsel = B_ZEXT; end
            OP_ORI:  begin c.unit = U_LOGIC; c.lop = L_OR;  c.bsel = B_ZEXT; end
            OP_XORI: begin c.unit = U_LOGIC; c.lop = L_XOR; c.bsel = B_ZEXT; end
            OP_LUI:  begin c.unit = U_PASS;  c.bsel = B_UPPER; end
            default: c.unit = U_ZERO;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
    import int_exec_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  bsel_e             bsel,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;
    logic [DATA_W-1:0] imm_upper;

    assign imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign imm_zext  = {{PAD_W{1'b0}}, imm};
    assign imm_upper = {imm, {PAD_W{1'b0}}};

    always_comb begin
        case (bsel)
            B_SEXT:  opnd_b = imm_sext;
            B_ZEXT:  opnd_b = imm_zext;
            B_UPPER: opnd_b = imm_upper;
            default: opnd_b = reg_b;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic              sub,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] cin;

    assign b_eff = b ^ {DATA_W{sub}};
    assign cin   = {{(DATA_W-1){1'b0}}, sub};
    assign sum   = a + b_eff + cin;
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic              shl,
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [0:SH_W];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        logic [DATA_W-1:0] moved;
        assign moved = shl ? (stage[k] << DIST) : (stage[k] >> DIST);
        assign stage[k+1] = amt[k] ? moved : stage[k];
    end

    assign dout = stage[SH_W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import int_exec_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic_e            lop,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (lop)
            L_OR:    y = a | b;
            L_NOR:   y = ~(a | b);
            L_XOR:   y = a ^ b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_exec_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] shift_y;
    logic [DATA_W-1:0] logic_y;

    assign ctrl = decode_op(op_sel);

    alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .bsel   (ctrl.bsel),
        .reg_b  (src_b),
        .imm    (imm16),
        .opnd_b (opnd_b)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_arith (
        .sub (ctrl.sub),
        .a   (src_a),
        .b   (opnd_b),
        .sum (arith_y)
    );

    alu_barrel #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .shl  (ctrl.shl),
        .din  (src_a),
        .amt  (shamt),
        .dout (shift_y)
    );

    alu_bitwise #(.DATA_W(DATA_W)) u_logic (
        .lop (ctrl.lop),
        .a   (src_a),
        .b   (opnd_b),
        .y   (logic_y)
    );

    always_comb begin
        case (ctrl.unit)
            U_ARITH: result = arith_y;
            U_SHIFT: result = shift_y;
            U_LOGIC: result = logic_y;
            U_PASS:  result = opnd_b;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_alu_chk.sv
module int_exec_alu_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm16,
    input logic [SH_W-1:0]   shamt,
    input logic [DATA_W-1:0] result
);
    localparam int PAD_W = DATA_W - IMM_W;

    always_comb begin
        // R3
        if (op_sel == 4'd1) begin
            sub_inverse_chk: assert (result + src_b == src_a);
        end
        // R4
        if (op_sel == 4'd8) begin
            addi_sext_chk: assert (result - src_a == {{PAD_W{imm16[IMM_W-1]}}, imm16});
        end
        // R5
        if (op_sel == 4'd9) begin
            andi_upper_clear_chk: assert (result[DATA_W-1:IMM_W] == '0);
        end
        // R6
        if ((op_sel == 4'd2 || op_sel == 4'd3) && shamt == '0) begin
            shift_zero_ident_chk: assert (result == src_a);
        end
        // R8
        if (op_sel == 4'd6) begin
            nor_disjoint_chk: assert ((result & (src_a | src_b)) == '0);
        end
        // R9
        if (op_sel == 4'd12) begin
            lui_low_clear_chk: assert (result[PAD_W-1:0] == '0 && result[DATA_W-1:PAD_W] == imm16);
        end
        // R10
        if (op_sel > 4'd12) begin
            unused_zero_chk: assert (result == '0);
        end
    end
endmodule

bind int_exec_alu int_exec_alu_chk #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SH_W   (SH_W)
) u_chk (.*);

// File: tb/int_exec_alu_test.sv
module int_exec_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    // Vector layout: tag[144:121] op[120:117] a[116:85] b[84:53] imm[52:37] sh[36:32] exp[31:0]
    localparam logic [144:0] VEC [0:NVEC-1] = '{
        {"R1 ", 4'd0,  32'h0000_0005, 32'h0000_0007, 16'hFFFF, 5'd31, 32'h0000_000C},
        {"R2 ", 4'd0,  32'hFFFF_FFFF, 32'h0000_0002, 16'h0000, 5'd0,  32'h0000_0001},
        {"R1 ", 4'd1,  32'h0000_000A, 32'h0000_0003, 16'h1234, 5'd7,  32'h0000_0007},
        {"R3 ", 4'd1,  32'h0000_0003, 32'h0000_000A, 16'h0000, 5'd0,  32'hFFFF_FFF9},
        {"R2 ", 4'd1,  32'h0000_0000, 32'h0000_0001, 16'h0000, 5'd0,  32'hFFFF_FFFF},
        {"R4 ", 4'd8,  32'h0000_0000, 32'hDEAD_BEEF, 16'h8000, 5'd3,  32'hFFFF_8000},
        {"R4 ", 4'd8,  32'h0000_0001, 32'hDEAD_BEEF, 16'h7FFF, 5'd0,  32'h0000_8000},
        {"R4 ", 4'd8,  32'h0000_0010, 32'h0000_0000, 16'hFFFF, 5'd0,  32'h0000_000F},
        {"R5 ", 4'd10, 32'h0000_0000, 32'hFFFF_FFFF, 16'h8000, 5'd0,  32'h0000_8000},
        {"R5 ", 4'd10, 32'h09C3_5D9C, 32'h0000_0000, 16'h0FFF, 5'd0,  32'h09C3_5FFF},
        {"R5 ", 4'd9,  32'h09C3_5D9C, 32'hFFFF_FFFF, 16'h0FFF, 5'd0,  32'h0000_0D9C},
        {"R5 ", 4'd11, 32'hFFFF_0000, 32'h1234_5678, 16'hFFFF, 5'd0,  32'hFFFF_FFFF},
        {"R6 ", 4'd2,  32'hB800_0009, 32'hFFFF_FFFF, 16'h0000, 5'd4,  32'h8000_0090},
        {"R6 ", 4'd2,  32'h1234_5678, 32'h0000_0000, 16'h0000, 5'd0,  32'h1234_5678},
        {"R6 ", 4'd2,  32'h0000_0003, 32'h0000_0000, 16'h0000, 5'd31, 32'h8000_0000},
        {"R6 ", 4'd3,  32'h8000_0000, 32'h0000_0000, 16'h0000, 5'd31, 32'h0000_0001},
        {"R6 ", 4'd3,  32'hF000_000F, 32'h0000_0000, 16'h0000, 5'd4,  32'h0F00_0000},
        {"R7 ", 4'd4,  32'h632F_0D59, 32'h0000_3C00, 16'hFFFF, 5'd0,  32'h0000_0C00},
        {"R7 ", 4'd5,  32'hF0F0_0000, 32'h0000_0F0F, 16'h0000, 5'd0,  32'hF0F0_0F0F},
        {"R7 ", 4'd7,  32'hFFFF_0000, 32'h0F0F_0F0F, 16'h0000, 5'd0,  32'hF0F0_0F0F},
        {"R8 ", 4'd6,  32'h1234_5678, 32'h0000_0000, 16'h0000, 5'd0,  32'hEDCB_A987},
        {"R8 ", 4'd6,  32'hF000_0000, 32'h0000_000F, 16'hFFFF, 5'd0,  32'h0FFF_FFF0},
        {"R9 ", 4'd12, 32'h5555_5555, 32'h1111_1111, 16'hAAAA, 5'd0,  32'hAAAA_0000},
        {"R10", 4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 32'h0000_0000},
        {"R10", 4'd15, 32'h1234_5678, 32'h8765_4321, 16'h8000, 5'd1,  32'h0000_0000}
    };

    logic        clk;
    logic [3:0]  op_sel;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic [15:0] imm16;
    logic [4:0]  shamt;
    logic [31:0] result;

    int checks;
    int fails;
    bit done;

    int_exec_alu uut (
        .op_sel (op_sel),
        .src_a  (src_a),
        .src_b  (src_b),
        .imm16  (imm16),
        .shamt  (shamt),
        .result (result)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic run_case(input logic [23:0] tag, input logic [3:0] op,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [15:0] imm, input logic [4:0] sh,
                            input logic [31:0] exp);
        @(posedge clk);
        op_sel = op;
        src_a  = a;
        src_b  = b;
        imm16  = imm;
        shamt  = sh;
        @(negedge clk);
        checks++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: actual %h expected %h",
                     tag, op, a, b, imm, sh, result, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] upper;
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        op_sel = 4'd0;
        src_a  = '0;
        src_b  = '0;
        imm16  = '0;
        shamt  = '0;

        // R12: result settles with no clock edge between drive and sample
        #1;
        checks++;
        if (result !== 32'h0) begin
            fails++;
            $display("FAIL R12 initial add of zeros: actual %h expected 00000000", result);
        end
        src_a = 32'h0000_0021;
        src_b = 32'h0000_0002;
        #1;
        checks++;
        if (result !== 32'h0000_0023) begin
            fails++;
            $display("FAIL R12 no-edge add: actual %h expected 00000023", result);
        end

        for (int i = 0; i < NVEC; i++) begin
            run_case(VEC[i][144:121], VEC[i][120:117], VEC[i][116:85], VEC[i][84:53],
                     VEC[i][52:37], VEC[i][36:32], VEC[i][31:0]);
        end

        // R6 walking shift across every count
        for (int s = 0; s < 32; s++) begin
            run_case("R6 ", 4'd2, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 5'(s), 32'h1 << s);
            run_case("R6 ", 4'd3, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'(s), 32'h8000_0000 >> s);
        end

        // R11 register forms ignore imm16, immediate forms ignore src_b
        run_case("R11", 4'd4, 32'hFFFF_FFFF, 32'h0000_00F0, 16'hFFFF, 5'd0, 32'h0000_00F0);
        run_case("R11", 4'd10, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0001, 5'd0, 32'h0000_0001);
        run_case("R11", 4'd2, 32'h0000_0001, 32'hFFFF_FFFF, 16'hFFFF, 5'd1, 32'h0000_0002);

        // R8 bitwise NOT via NOR with zero
        run_case("R8 ", 4'd6, 32'h0000_0000, 32'h0000_0000, 16'h0, 5'd0, 32'hFFFF_FFFF);

        // R9 then R5: build a full 32-bit constant in two steps
        run_case("R9 ", 4'd12, 32'h0, 32'h0, 16'hAAAA, 5'd0, 32'hAAAA_0000);
        upper = result;
        run_case("R5 ", 4'd10, upper, 32'h0, 16'hF0F0, 5'd0, 32'hAAAA_F0F0);

        // R2 wrap on the largest positive plus one
        run_case("R2 ", 4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 5'd0, 32'h8000_0000);
        // R10 remaining unused code
        run_case("R10", 4'd14, 32'hFFFF_FFFF, 32'h0000_0001, 16'hFFFF, 5'd3, 32'h0000_0000);

        done = 1'b1;
        report();
        $finish;
    end
endmodule